// File: doc/BRIEF.md
# Fractional Clock Generator Slice

This block divides a source clock by a programmable divisor made of a 16-bit integer part and a 16-bit fraction, and produces a gated output clock. It runs entirely in the source clock domain. A divisor integer of N gives an output period of N source cycles. The fraction is added into a running accumulator once per output period. Each carry out of that accumulator appends one extra low source cycle to the period, so the long-run average period is N plus the fraction.

The enable input starts and stops the output only on period boundaries, so no pulse is ever cut short. A separate kill input clears the whole slice asynchronously. A 2-bit phase field delays the effective enable by a selectable number of source cycles. A rising edge on the nudge input slips the output by one source cycle. With duty correction on and an odd integer divisor, a helper register clocked on the falling source edge extends the high phase by half a source cycle. The high and low times then match exactly.

A typical use is one slice per generated clock, with the source already chosen upstream. Software-style control fields arrive as plain input ports.

Top module: `frac_clkgen_slice`

## Requirements
- R1: With a zero fraction and integer divisor N in 1..65535, every output period lasts exactly N source cycles.
- R2: An integer divisor of 0 divides by 65536: the period is 65536 source cycles and the high time is 32768 source cycles.
- R3: Without duty correction, the output is high for N/2 source cycles when N is even and (N-1)/2 source cycles when N is odd and at least 3. When N is 1, the output passes the source clock: it is high in the first half of every source cycle.
- R4: With duty correction set and N odd and at least 3, the output is high for exactly N half source cycles. It falls at the falling source edge in the middle of the cycle.
- R5: The accumulator starts at zero after reset or kill and adds the fraction F at the start of each period. Period i (counting from 1) lasts N + (floor(i·F/65536) − floor((i−1)·F/65536)) cycles, and each extra cycle is low.
- R6: If enable is first sampled high at rising edge k, the output first rises right after rising edge k+1+P, where P is the value of the phase field.
- R7: After enable falls, the current period, including any appended cycles, runs to its end. Every high pulse has its full length, and the output then stays low.
- R8: A rising edge on the nudge input while the slice is running adds exactly one low source cycle to one output period.
- R9: Kill clears the slice without waiting for a clock edge. The output and the running flag drop at once, and the slice stays idle while kill is held.
- R10: The running flag is high from the edge that starts the first period until the edge that ends the last one.
- R11: After reset, the output is low and the running flag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clean start/stop request |
| kill_i | input | 1 | Asynchronous stop, active high; drop en_i before releasing it |
| phase_i | input | 2 | Enable delay in source cycles (0..3) |
| nudge_i | input | 1 | Rising edge slips the output by one source cycle |
| dc50_i | input | 1 | Duty correction for odd integer divisors |
| div_int_i | input | 16 | Integer divisor; 0 means 65536 |
| div_frac_i | input | 16 | Fractional divisor in units of 1/65536 |
| clk_o | output | 1 | Generated clock |
| running_o | output | 1 | Generator active |

## Verification
Several properties are checked on every cycle: the period counter stays below the latched divisor, the high phase only ever covers the first half of a period, and appended cycles are always low. Divide-by-one pass mode only occurs with a unit divisor. Stopping only happens on a period boundary, and the half-cycle extension only fires for an odd divisor with correction on. Other behaviour can only be shown by the bench, which samples the output in every half cycle. This covers absolute period and high-time lengths, the exact carry pattern of the fraction, enable latency per phase setting, the single slip from a nudge, and the immediate effect of kill.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    // Generator sequencing states
    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,  // output parked low
        GS_COUNT   = 2'd1,  // counting through the N cycles of a period
        GS_STRETCH = 2'd2   // appended low cycles (fraction carry or nudge)
    } gen_state_e;

endpackage

// File: rtl/fcg_en_delay.sv
module fcg_en_delay #(
    parameter int unsigned PHASE_W = 2
) (
    input  logic               clk_i,
    input  logic               clr_i,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] sel_i,
    output logic               en_o
);
    localparam int unsigned DEPTH = 1 << PHASE_W;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], en_i};
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // Tap 0 is one cycle after the request, tap k adds k more cycles
    assign en_o = pipe_q[sel_i];

endmodule

// File: rtl/fcg_frac_acc.sv
module fcg_frac_acc #(
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk_i,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);
    logic [FRAC_W:0]   sum;
    logic [FRAC_W-1:0] acc_d, acc_q;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_i};
        carry_o = sum[FRAC_W];
        acc_d   = step_i ? sum[FRAC_W-1:0] : acc_q;
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R5: the accumulator only moves at a period start
    a_r5_acc_moves_on_step: assert property (@(posedge clk_i) disable iff (clr_i)
        !step_i |=> $stable(acc_q));

endmodule

// File: rtl/fcg_duty_out.sv
module fcg_duty_out (
    input  logic clk_i,
    input  logic clr_i,
    input  logic hi_i,
    input  logic dc_odd_i,
    input  logic pass_i,
    output logic clk_o
);
    logic ext_d, ext_q;

    always_comb begin
        ext_d = hi_i & dc_odd_i;
    end

    // Falling-edge helper: holds the high phase for half a cycle more
    always_ff @(negedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_d;
        end
    end

    assign clk_o = pass_i ? clk_i : (hi_i | ext_q);

    // R4: the half-cycle extension is only present for an odd corrected divisor
    a_r4_ext_only_odd: assert property (@(posedge clk_i) disable iff (clr_i)
        ext_q |-> dc_odd_i);

endmodule

// File: rtl/frac_clkgen_slice.sv
module frac_clkgen_slice
    import fcg_pkg::*;
#(
    parameter int unsigned INT_W   = 16,
    parameter int unsigned FRAC_W  = 16,
    parameter int unsigned PHASE_W = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic               kill_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               nudge_i,
    input  logic               dc50_i,
    input  logic [INT_W-1:0]   div_int_i,
    input  logic [FRAC_W-1:0]  div_frac_i,
    output logic               clk_o,
    output logic               running_o
);
    localparam int unsigned CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        gen_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] n;
        logic [1:0]       extra;
        logic             dcodd;
        logic             pass;
        logic             hi;
        logic             nud_prev;
        logic             nud_pend;
    } core_t;

    core_t            q, d;
    logic             clr;
    logic             en_eff;
    logic             carry;
    logic             do_start;
    logic             go_idle;
    logic             nud_edge;
    logic [CNT_W-1:0] div_n;
    logic [CNT_W-1:0] half_n;

    assign clr = ~rst_ni | kill_i;

    fcg_en_delay #(.PHASE_W(PHASE_W)) u_dly (
        .clk_i (clk_i),
        .clr_i (clr),
        .en_i  (en_i),
        .sel_i (phase_i),
        .en_o  (en_eff)
    );

    fcg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk_i   (clk_i),
        .clr_i   (clr),
        .step_i  (do_start),
        .frac_i  (div_frac_i),
        .carry_o (carry)
    );

    always_comb begin
        div_n    = (div_int_i == '0) ? {1'b1, {INT_W{1'b0}}} : {1'b0, div_int_i};
        half_n   = q.n >> 1;
        nud_edge = nudge_i & ~q.nud_prev;
        d          = q;
        d.nud_prev = nudge_i;
        do_start   = 1'b0;
        go_idle    = 1'b0;

        unique case (q.st)
            GS_IDLE: begin
                d.nud_pend = 1'b0;
                d.hi       = 1'b0;
                d.pass     = 1'b0;
                if (en_eff) begin
                    do_start = 1'b1;
                end
            end
            GS_COUNT: begin
                d.nud_pend = q.nud_pend | nud_edge;
                if (q.cnt == q.n - ONE) begin
                    if (q.extra != 2'd0) begin
                        d.st    = GS_STRETCH;
                        d.extra = q.extra - 2'd1;
                        d.hi    = 1'b0;
                        d.pass  = 1'b0;
                    end else if (en_eff) begin
                        do_start = 1'b1;
                    end else begin
                        go_idle = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + ONE;
                    d.hi  = (q.cnt + ONE) < half_n;
                end
            end
            GS_STRETCH: begin
                d.nud_pend = q.nud_pend | nud_edge;
                if (q.extra != 2'd0) begin
                    d.extra = q.extra - 2'd1;
                end else if (en_eff) begin
                    do_start = 1'b1;
                end else begin
                    go_idle = 1'b1;
                end
            end
            default: begin
                go_idle = 1'b1;
            end
        endcase

        if (do_start) begin
            d.st       = GS_COUNT;
            d.cnt      = '0;
            d.n        = div_n;
            d.hi       = (div_n > ONE);
            d.pass     = (div_n == ONE);
            d.dcodd    = dc50_i & div_n[0] & (div_n != ONE);
            d.extra    = {1'b0, carry} + {1'b0, q.nud_pend};
            d.nud_pend = (q.st != GS_IDLE) & nud_edge;
        end

        if (go_idle) begin
            d.st       = GS_IDLE;
            d.hi       = 1'b0;
            d.pass     = 1'b0;
            d.dcodd    = 1'b0;
            d.extra    = 2'd0;
            d.nud_pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge clr) begin
        if (clr) begin
            q   <= '0;
            q.n <= ONE;
        end else begin
            q <= d;
        end
    end

    fcg_duty_out u_out (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .hi_i     (q.hi),
        .dc_odd_i (q.dcodd),
        .pass_i   (q.pass),
        .clk_o    (clk_o)
    );

    assign running_o = (q.st != GS_IDLE);

    // R1: the position inside a period never reaches the latched divisor
    a_r1_cnt_in_period: assert property (@(posedge clk_i) disable iff (clr)
        (q.st != GS_IDLE) |-> (q.cnt < q.n));

    // R3: the high phase only covers the first half of a period
    a_r3_high_first_half: assert property (@(posedge clk_i) disable iff (clr)
        q.hi |-> (q.st == GS_COUNT) && (q.cnt < (q.n >> 1)));

    // R3: source pass-through only with a unit divisor
    a_r3_pass_unit: assert property (@(posedge clk_i) disable iff (clr)
        q.pass |-> (q.n == ONE));

    // R5: appended cycles are low
    a_r5_stretch_low: assert property (@(posedge clk_i) disable iff (clr)
        (q.st == GS_STRETCH) |-> (!q.hi && !q.pass));

    // R7: the generator stops only at a period boundary
    a_r7_stop_on_boundary: assert property (@(posedge clk_i) disable iff (clr)
        $fell(running_o) |-> $past((q.extra == 2'd0) &&
            ((q.st == GS_STRETCH) || ((q.st == GS_COUNT) && (q.cnt == q.n - ONE)))));

endmodule

// File: tb/frac_clkgen_slice_test.sv
module frac_clkgen_slice_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        kill = 1'b0;
    logic [1:0]  phase = 2'd0;
    logic        nudge = 1'b0;
    logic        dc50 = 1'b0;
    logic [15:0] div_int = 16'd1;
    logic [15:0] div_frac = 16'd0;
    logic        clk_out;
    logic        running;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clkgen_slice uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .kill_i     (kill),
        .phase_i    (phase),
        .nudge_i    (nudge),
        .dc50_i     (dc50),
        .div_int_i  (div_int),
        .div_frac_i (div_frac),
        .clk_o      (clk_out),
        .running_o  (running)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Half-cycle monitor: periods between rises, high lengths, in half cycles
    bit mon_on = 1'b0;
    int hidx, last_rise, hi_run, np, nh;
    logic prev;
    int per_h [0:255];
    int hi_h  [0:255];

    always @(clk) begin
        #2;
        if (mon_on) begin
            hidx++;
            if (clk_out && !prev) begin
                if (last_rise >= 0 && np < 256) begin
                    per_h[np] = hidx - last_rise;
                    np++;
                end
                last_rise = hidx;
                hi_run = 0;
            end
            if (clk_out) hi_run++;
            if (!clk_out && prev && nh < 256) begin
                hi_h[nh] = hi_run;
                nh++;
            end
            prev = clk_out;
        end
    end

    task automatic mon_reset();
        np = 0; nh = 0; hidx = 0; last_rise = -1; hi_run = 0;
        prev = clk_out; mon_on = 1'b1;
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        at_neg();
        rst_n = 1'b0;
        en = 1'b0;
        repeat (2) @(posedge clk);
        at_neg();
        rst_n = 1'b1;
    endtask

    function automatic int exp_high(input int n, input bit dc);
        if (n == 1) return 1;
        if (n % 2 == 0) return n;
        return dc ? n : n - 1;
    endfunction

    function automatic int carry_at(input int i, input int f);
        return ((i * f) >>> 16) - (((i - 1) * f) >>> 16);
    endfunction

    task automatic stop_and_wait();
        at_neg();
        en = 1'b0;
        wait (!running);
        repeat (6) @(posedge clk);
        #2;
    endtask

    task automatic run_div(input int n, input bit dc, input int frac, input int k, input string req);
        at_neg();
        div_int = n[15:0];
        dc50 = dc;
        div_frac = frac[15:0];
        mon_reset();
        en = 1'b1;
        wait (np >= k);
        check("R10", "running while active", longint'(running), 1);
        stop_and_wait();
        for (int i = 0; i < k; i++)
            check(req, $sformatf("period %0d halves n=%0d f=%0d", i, n, frac),
                  per_h[i], 2 * (n + carry_at(i + 1, frac)));
        for (int i = 0; i < nh; i++)
            check(req, $sformatf("high halves n=%0d dc=%0d", n, dc), hi_h[i], exp_high(n, dc));
        check("R7", "every pulse completed", nh, np + 1);
        check("R7", "output low after stop", longint'(clk_out), 0);
        check("R10", "running low after stop", longint'(running), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        int count8, count10, got;
        seed = $urandom(32'd1234);

        // R11: reset state
        repeat (3) @(posedge clk);
        #2;
        check("R11", "clk_o in reset", longint'(clk_out), 0);
        check("R11", "running in reset", longint'(running), 0);
        do_reset();
        #2;
        check("R11", "clk_o after reset", longint'(clk_out), 0);
        check("R11", "running after reset", longint'(running), 0);

        // R1, R3, R4: directed integer divisors
        run_div(1, 1'b0, 0, 4, "R3");
        run_div(1, 1'b1, 0, 3, "R3");
        run_div(2, 1'b0, 0, 4, "R1");
        run_div(3, 1'b0, 0, 4, "R3");
        run_div(3, 1'b1, 0, 4, "R4");
        run_div(5, 1'b1, 0, 3, "R4");
        run_div(7, 1'b1, 0, 3, "R4");
        run_div(7, 1'b0, 0, 3, "R3");
        run_div(8, 1'b1, 0, 3, "R1");

        // R6: enable latency per phase setting
        for (int ph = 0; ph < 4; ph++) begin
            at_neg();
            div_int = 16'd4; dc50 = 1'b0; div_frac = 16'd0;
            phase = ph[1:0];
            en = 1'b1;
            got = 0;
            for (int c = 1; c <= 8; c++) begin
                @(posedge clk);
                #2;
                if (clk_out && got == 0) got = c;
            end
            check("R6", $sformatf("first rise edge, phase %0d", ph), got, 2 + ph);
            stop_and_wait();
        end
        at_neg();
        phase = 2'd0;

        // R8: single nudge
        at_neg();
        div_int = 16'd4; dc50 = 1'b0; div_frac = 16'd0;
        mon_reset();
        en = 1'b1;
        wait (np >= 2);
        at_neg(); nudge = 1'b1;
        at_neg(); nudge = 1'b0;
        wait (np >= 6);
        stop_and_wait();
        count8 = 0; count10 = 0;
        for (int i = 0; i < 6; i++) begin
            if (per_h[i] == 8) count8++;
            if (per_h[i] == 10) count10++;
        end
        check("R8", "lengthened periods", count10, 1);
        check("R8", "normal periods", count8, 5);

        // R5: fractional divisor from a cleared accumulator
        do_reset();
        run_div(3, 1'b0, 16'h4000, 8, "R5");
        do_reset();
        run_div(2, 1'b0, int'($urandom % 65536), 10, "R5");
        do_reset();
        run_div(5, 1'b1, 16'hA000, 6, "R5");

        // R1/R3/R4 constrained random
        for (int it = 0; it < 6; it++) begin
            int n;
            bit dc;
            n = 1 + int'($urandom % 9);
            dc = bit'($urandom % 2);
            run_div(n, dc, 0, 3, (n % 2 == 1 && n > 1 && dc) ? "R4" : "R1");
        end

        // R9: asynchronous kill while high
        at_neg();
        div_int = 16'd6; dc50 = 1'b0; div_frac = 16'd0;
        mon_reset();
        en = 1'b1;
        wait (np >= 1);
        wait (clk_out == 1'b1);
        #1;
        kill = 1'b1;
        #1;
        check("R9", "clk_o right after kill", longint'(clk_out), 0);
        check("R9", "running right after kill", longint'(running), 0);
        at_neg(); en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R9", "clk_o while killed", longint'(clk_out), 0);
        at_neg(); kill = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        check("R9", "idle after kill release", longint'(running), 0);

        // R2: zero integer divisor means 65536
        at_neg();
        div_int = 16'd0; dc50 = 1'b0; div_frac = 16'd0;
        mon_reset();
        en = 1'b1;
        wait (np >= 1);
        check("R2", "period halves", per_h[0], 131072);
        check("R2", "high halves", hi_h[0], 65536);
        #1;
        kill = 1'b1;
        at_neg(); en = 1'b0;
        repeat (2) @(posedge clk);
        at_neg(); kill = 1'b0;
        mon_on = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule